// File: doc/BRIEF.md
# Trace Write Address Translation Cache

This block is a two-entry translation cache reserved for the addresses that trace output writes use. It is kept apart from the translation cache that serves loads and stores. A trace write arrives as a virtual address. When the address hits, the block returns the physical address in the same cycle. When it misses, the block raises a refill request, and an external page walker answers that request through a fill port. Because trace pages are rarely revisited once they are full, two entries are enough.

Each entry is tagged with a virtual page number, an address-space ID (with a global flag) and a virtual-machine ID. A mode input picks the translation context that lookups must match. The default context is the one belonging to the mode that trace is delegated to. The alternate context comes from dedicated trace ASID/VMID registers and may also select bare mode. The block has no privilege-mode input, so the executing mode never alters the context.

A single fence port carries optional page, ASID and VMID qualifiers. With it, supervisor and hypervisor fences remove entries using the same match rules as the main translation cache. An entry filled with an alternate VMID therefore survives a guest fence that names the current guest VMID.

Top module: `trace_xlat_tlb`

## Requirements
- R1: After reset no entry is valid. In a non-bare context every lookup misses and raises `rf_req`.
- R2: A lookup hits when a valid entry has a matching page number, a matching ASID or the global flag set, and a VMID equal to the selected context VMID. On a hit, `lk_pa` is the entry's physical page concatenated with the 12-bit page offset of `lk_va`, in the same cycle.
- R3: When `mode_alt`=0 the selected ASID/VMID are `dflt_asid`/`dflt_vmid`, and when `mode_alt`=1 they are `alt_asid`/`alt_vmid`. A change to the default IDs retags lookups without invalidating entries.
- R4: A lookup miss drives `rf_req` high in the same cycle, with `rf_vpn` set to `lk_va[38:12]` and with the selected ASID and VMID.
- R5: A fill writes the entry named by a round-robin pointer. With two entries, the third fill replaces the first.
- R6: A fence removes, at the next clock edge, every entry that matches all of its enabled qualifiers. A disabled qualifier matches everything, and an ASID-qualified fence spares global entries.
- R7: A VMID-qualified fence leaves in place an entry whose VMID differs from the fence VMID, including one filled under the alternate context.
- R8: When `mode_alt`=1 and `alt_bare`=1, every lookup hits with `lk_pa` equal to `lk_va` zero-extended, and `rf_req` stays low.
- R9: A change of `mode_alt`, `alt_asid`, `alt_vmid` or `alt_bare` invalidates both entries at the next clock edge.
- R10: When a fill and a fence that matches the fill's tags arrive in the same cycle, the new entry is left invalid. A non-matching fence in that cycle does not block the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_alt | input | 1 | 0 selects the default context, 1 selects the alternate trace context |
| dflt_asid | input | 16 | ASID of the delegated mode's translation context |
| dflt_vmid | input | 14 | VMID of the delegated mode's translation context |
| alt_asid | input | 16 | Alternate trace ASID |
| alt_vmid | input | 14 | Alternate trace VMID |
| alt_bare | input | 1 | Alternate context requests untranslated addresses |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 39 | Trace write virtual address |
| lk_hit | output | 1 | Lookup translated |
| lk_miss | output | 1 | Lookup missed |
| lk_pa | output | 56 | Translated physical address |
| rf_req | output | 1 | Refill request to the walker |
| rf_vpn | output | 27 | Page number to walk |
| rf_asid | output | 16 | ASID of the selected context |
| rf_vmid | output | 14 | VMID of the selected context |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_vpn | input | 27 | Page number of the fill |
| fill_ppn | input | 44 | Physical page of the fill |
| fill_asid | input | 16 | ASID tag of the fill |
| fill_vmid | input | 14 | VMID tag of the fill |
| fill_glb | input | 1 | Fill is a global mapping |
| fn_valid | input | 1 | Fence strobe |
| fn_va_en | input | 1 | Fence is qualified by page number |
| fn_vpn | input | 27 | Fence page number |
| fn_asid_en | input | 1 | Fence is qualified by ASID |
| fn_asid | input | 16 | Fence ASID |
| fn_vmid_en | input | 1 | Fence is qualified by VMID |
| fn_vmid | input | 14 | Fence VMID |

## Verification
The assertions assume that the walker delivers a fill only for a translation that is currently missing, with tags that match the selected context. Under that assumption two entries never hit at once and a fill always lands on an empty slot or on the oldest one. The stimulus refills a page only after it has been observed missing, and it never fills while bare mode is active. Context registers change only at negative clock edges, one per step, and fills wait one cycle after any context change, so no fill is lost to the flush unless a test intends it.

// File: rtl/trace_tlb_pkg.sv
package trace_tlb_pkg;

    // Source of the translation context used for trace writes
    typedef enum logic {
        CTX_DELEG = 1'b0,
        CTX_TRACE = 1'b1
    } ctx_src_e;

    localparam int unsigned TT_PAGE_OFF_W = 12;

endpackage

// File: rtl/trace_tlb_ctx.sv
module trace_tlb_ctx
    import trace_tlb_pkg::*;
#(
    parameter int unsigned ASID_W = 16,
    parameter int unsigned VMID_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctx_src_e          mode_sel,
    input  logic [ASID_W-1:0] dflt_asid,
    input  logic [VMID_W-1:0] dflt_vmid,
    input  logic [ASID_W-1:0] alt_asid,
    input  logic [VMID_W-1:0] alt_vmid,
    input  logic              alt_bare,
    output logic [ASID_W-1:0] sel_asid,
    output logic [VMID_W-1:0] sel_vmid,
    output logic              sel_bare,
    output logic              ctx_flush
);

    typedef struct packed {
        logic              alt;
        logic              bare;
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
    } shadow_t;

    shadow_t shadow_d, shadow_q;

    always_comb begin
        shadow_d = '{alt: (mode_sel == CTX_TRACE), bare: alt_bare,
                     asid: alt_asid, vmid: alt_vmid};
        ctx_flush = (shadow_d != shadow_q);
        if (mode_sel == CTX_TRACE) begin
            sel_asid = alt_asid;
            sel_vmid = alt_vmid;
            sel_bare = alt_bare;
        end else begin
            sel_asid = dflt_asid;
            sel_vmid = dflt_vmid;
            sel_bare = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_d;
    end

endmodule

// File: rtl/trace_tlb_way.sv
module trace_tlb_way #(
    parameter int unsigned VPN_W  = 27,
    parameter int unsigned PPN_W  = 44,
    parameter int unsigned ASID_W = 16,
    parameter int unsigned VMID_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VMID_W-1:0] lk_vmid,
    input  logic              fill_we,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic              fill_glb,
    input  logic              fn_valid,
    input  logic              fn_va_en,
    input  logic [VPN_W-1:0]  fn_vpn,
    input  logic              fn_asid_en,
    input  logic [ASID_W-1:0] fn_asid,
    input  logic              fn_vmid_en,
    input  logic [VMID_W-1:0] fn_vmid,
    input  logic              flush_all,
    output logic              hit,
    output logic [PPN_W-1:0]  ppn
);

    typedef struct packed {
        logic              vld;
        logic              glb;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
    } ent_t;

    ent_t ent_d, ent_q;
    logic kill_old, kill_new;

    always_comb begin
        ent_d = ent_q;
        // fence against the stored tags
        kill_old = fn_valid
                 && (!fn_va_en   || fn_vpn == ent_q.vpn)
                 && (!fn_asid_en || (!ent_q.glb && fn_asid == ent_q.asid))
                 && (!fn_vmid_en || fn_vmid == ent_q.vmid);
        // fence against the tags arriving in this cycle
        kill_new = fn_valid
                 && (!fn_va_en   || fn_vpn == fill_vpn)
                 && (!fn_asid_en || (!fill_glb && fn_asid == fill_asid))
                 && (!fn_vmid_en || fn_vmid == fill_vmid);
        if (fill_we) begin
            ent_d.vld  = !kill_new && !flush_all;
            ent_d.glb  = fill_glb;
            ent_d.vpn  = fill_vpn;
            ent_d.ppn  = fill_ppn;
            ent_d.asid = fill_asid;
            ent_d.vmid = fill_vmid;
        end else if (kill_old || flush_all) begin
            ent_d.vld = 1'b0;
        end
        hit = ent_q.vld && (ent_q.vpn == lk_vpn)
            && (ent_q.glb || ent_q.asid == lk_asid)
            && (ent_q.vmid == lk_vmid);
        ppn = ent_q.ppn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assert_fence_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_we && kill_old) |=> !ent_q.vld);

    assert_ctx_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !ent_q.vld);

    assert_fill_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && kill_new) |=> !ent_q.vld);

    assert_fill_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !kill_new && !flush_all) |=> (ent_q.vld && ent_q.vpn == $past(fill_vpn)));

endmodule

// File: rtl/trace_xlat_tlb.sv
module trace_xlat_tlb
    import trace_tlb_pkg::*;
#(
    parameter int unsigned VA_W     = 39,
    parameter int unsigned PA_W     = 56,
    parameter int unsigned OFF_W    = TT_PAGE_OFF_W,
    parameter int unsigned ASID_W   = 16,
    parameter int unsigned VMID_W   = 14,
    parameter int unsigned NUM_WAYS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_alt,
    input  logic [ASID_W-1:0]     dflt_asid,
    input  logic [VMID_W-1:0]     dflt_vmid,
    input  logic [ASID_W-1:0]     alt_asid,
    input  logic [VMID_W-1:0]     alt_vmid,
    input  logic                  alt_bare,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_va,
    output logic                  lk_hit,
    output logic                  lk_miss,
    output logic [PA_W-1:0]       lk_pa,
    output logic                  rf_req,
    output logic [VA_W-OFF_W-1:0] rf_vpn,
    output logic [ASID_W-1:0]     rf_asid,
    output logic [VMID_W-1:0]     rf_vmid,
    input  logic                  fill_valid,
    input  logic [VA_W-OFF_W-1:0] fill_vpn,
    input  logic [PA_W-OFF_W-1:0] fill_ppn,
    input  logic [ASID_W-1:0]     fill_asid,
    input  logic [VMID_W-1:0]     fill_vmid,
    input  logic                  fill_glb,
    input  logic                  fn_valid,
    input  logic                  fn_va_en,
    input  logic [VA_W-OFF_W-1:0] fn_vpn,
    input  logic                  fn_asid_en,
    input  logic [ASID_W-1:0]     fn_asid,
    input  logic                  fn_vmid_en,
    input  logic [VMID_W-1:0]     fn_vmid
);

    localparam int unsigned VPN_W = VA_W - OFF_W;
    localparam int unsigned PPN_W = PA_W - OFF_W;
    localparam int unsigned PTR_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } repl_t;

    repl_t             repl_d, repl_q;
    logic [ASID_W-1:0] sel_asid;
    logic [VMID_W-1:0] sel_vmid;
    logic              sel_bare;
    logic              ctx_flush;
    logic              fill_we;
    logic              any_hit;
    logic [PPN_W-1:0]  hit_ppn;
    logic [NUM_WAYS-1:0] way_hit;
    logic [PPN_W-1:0]  way_ppn [NUM_WAYS];

    trace_tlb_ctx #(.ASID_W(ASID_W), .VMID_W(VMID_W)) ctx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (ctx_src_e'(mode_alt)),
        .dflt_asid (dflt_asid),
        .dflt_vmid (dflt_vmid),
        .alt_asid  (alt_asid),
        .alt_vmid  (alt_vmid),
        .alt_bare  (alt_bare),
        .sel_asid  (sel_asid),
        .sel_vmid  (sel_vmid),
        .sel_bare  (sel_bare),
        .ctx_flush (ctx_flush)
    );

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        trace_tlb_way #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) way_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .lk_vpn     (lk_va[VA_W-1:OFF_W]),
            .lk_asid    (sel_asid),
            .lk_vmid    (sel_vmid),
            .fill_we    (fill_we && (repl_q.ptr == PTR_W'(g))),
            .fill_vpn   (fill_vpn),
            .fill_ppn   (fill_ppn),
            .fill_asid  (fill_asid),
            .fill_vmid  (fill_vmid),
            .fill_glb   (fill_glb),
            .fn_valid   (fn_valid),
            .fn_va_en   (fn_va_en),
            .fn_vpn     (fn_vpn),
            .fn_asid_en (fn_asid_en),
            .fn_asid    (fn_asid),
            .fn_vmid_en (fn_vmid_en),
            .fn_vmid    (fn_vmid),
            .flush_all  (ctx_flush),
            .hit        (way_hit[g]),
            .ppn        (way_ppn[g])
        );
    end

    always_comb begin
        any_hit = 1'b0;
        hit_ppn = '0;
        // lowest index takes priority
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (way_hit[i]) begin
                any_hit = 1'b1;
                hit_ppn = way_ppn[i];
            end
        end
        fill_we = fill_valid && !sel_bare;
        repl_d  = repl_q;
        if (fill_we) begin
            if (repl_q.ptr == PTR_W'(NUM_WAYS - 1)) repl_d.ptr = '0;
            else                                    repl_d.ptr = repl_q.ptr + 1'b1;
        end
        lk_hit  = lk_valid && (sel_bare || any_hit);
        lk_miss = lk_valid && !lk_hit;
        lk_pa   = sel_bare ? PA_W'(lk_va) : {hit_ppn, lk_va[OFF_W-1:0]};
        rf_req  = lk_miss;
        rf_vpn  = lk_va[VA_W-1:OFF_W];
        rf_asid = sel_asid;
        rf_vmid = sel_vmid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) repl_q <= '0;
        else        repl_q <= repl_d;
    end

    assert_bare_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && sel_bare) |-> (lk_hit && !rf_req && lk_pa == PA_W'(lk_va)));

    assert_miss_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> (lk_valid && !lk_hit && rf_vpn == lk_va[VA_W-1:OFF_W]));

    assert_fifo_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (repl_q.ptr != $past(repl_q.ptr)));

    assert_hit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(way_hit) <= 1);

endmodule

// File: tb/trace_xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module trace_xlat_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_alt = 1'b0;
    logic [15:0] dflt_asid = 16'd5;
    logic [13:0] dflt_vmid = 14'd2;
    logic [15:0] alt_asid = '0;
    logic [13:0] alt_vmid = '0;
    logic        alt_bare = 1'b0;
    logic        lk_valid = 1'b0;
    logic [38:0] lk_va = '0;
    logic        lk_hit, lk_miss, rf_req;
    logic [55:0] lk_pa;
    logic [26:0] rf_vpn;
    logic [15:0] rf_asid;
    logic [13:0] rf_vmid;
    logic        fill_valid = 1'b0;
    logic [26:0] fill_vpn = '0;
    logic [43:0] fill_ppn = '0;
    logic [15:0] fill_asid = '0;
    logic [13:0] fill_vmid = '0;
    logic        fill_glb = 1'b0;
    logic        fn_valid = 1'b0, fn_va_en = 1'b0, fn_asid_en = 1'b0, fn_vmid_en = 1'b0;
    logic [26:0] fn_vpn = '0;
    logic [15:0] fn_asid = '0;
    logic [13:0] fn_vmid = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    trace_xlat_tlb dut_i (.*);

    typedef struct packed {
        logic [38:0] va;
        logic        hit;
        logic [55:0] pa;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{va: 39'h100123, hit: 1'b1, pa: 56'hAAA123},
        '{va: 39'h200FFF, hit: 1'b1, pa: 56'hBBBFFF},
        '{va: 39'h300000, hit: 1'b0, pa: 56'h0},
        '{va: 39'h101000, hit: 1'b0, pa: 56'h0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic look(input logic [38:0] va);
        lk_valid = 1'b1;
        lk_va    = va;
        #1;
    endtask

    task automatic fill(input logic [26:0] vpn, input logic [43:0] ppn,
                        input logic [15:0] asid, input logic [13:0] vmid, input logic glb);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        fill_asid = asid; fill_vmid = vmid; fill_glb = glb;
        step();
        fill_valid = 1'b0;
    endtask

    task automatic fence(input logic va_en, input logic [26:0] vpn,
                         input logic asid_en, input logic [15:0] asid,
                         input logic vmid_en, input logic [13:0] vmid);
        fn_valid = 1'b1; fn_va_en = va_en; fn_vpn = vpn;
        fn_asid_en = asid_en; fn_asid = asid; fn_vmid_en = vmid_en; fn_vmid = vmid;
        step();
        fn_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: empty after reset
        look(39'h100123);
        check("R1 hit", lk_hit, 0);
        check("R1 req", rf_req, 1);

        // fills in the default context
        fill(27'h100, 44'hAAA, 16'd5, 14'd2, 1'b0);
        fill(27'h200, 44'hBBB, 16'd9, 14'd2, 1'b1);

        // R2: table of lookups
        foreach (VECS[i]) begin
            look(VECS[i].va);
            check("R2 hit", lk_hit, VECS[i].hit);
            if (VECS[i].hit) check("R2 pa", lk_pa, VECS[i].pa);
        end

        // R4: miss request fields
        look(39'h300ABC);
        check("R4 req", rf_req, 1);
        check("R4 vpn", rf_vpn, 27'h300);
        check("R4 asid", rf_asid, 16'd5);
        check("R4 vmid", rf_vmid, 14'd2);

        // R3: default context retags without flushing
        dflt_asid = 16'd6;
        look(39'h100000);
        check("R3 asid retag miss", lk_hit, 0);
        look(39'h200000);
        check("R3 global hit", lk_hit, 1);
        dflt_asid = 16'd5;
        dflt_vmid = 14'd3;
        look(39'h200000);
        check("R3 vmid retag miss", lk_hit, 0);
        step();
        dflt_vmid = 14'd2;
        look(39'h100000);
        check("R3 entry kept", lk_hit, 1);

        // R5: third fill replaces the first
        fill(27'h300, 44'hCCC, 16'd5, 14'd2, 1'b0);
        look(39'h100000);
        check("R5 oldest evicted", lk_hit, 0);
        look(39'h200000);
        check("R5 second kept", lk_hit, 1);
        look(39'h300456);
        check("R5 new pa", lk_pa, 56'hCCC456);

        // R6: fences
        fence(1'b0, '0, 1'b1, 16'd9, 1'b0, '0);
        look(39'h200000);
        check("R6 global spared", lk_hit, 1);
        fence(1'b1, 27'h300, 1'b0, '0, 1'b0, '0);
        look(39'h300000);
        check("R6 page fence", lk_hit, 0);
        look(39'h200000);
        check("R6 other page kept", lk_hit, 1);
        fence(1'b0, '0, 1'b0, '0, 1'b0, '0);
        look(39'h200000);
        check("R6 wildcard fence", lk_hit, 0);

        // alternate context
        mode_alt = 1'b1; alt_asid = 16'd4; alt_vmid = 14'd7;
        step();
        look(39'h400000);
        check("R3 alt asid", rf_asid, 16'd4);
        check("R3 alt vmid", rf_vmid, 14'd7);
        fill(27'h400, 44'hDDD, 16'd4, 14'd7, 1'b0);
        look(39'h400010);
        check("R3 alt hit pa", lk_pa, 56'hDDD010);

        // R7: guest fence with other VMID
        fence(1'b0, '0, 1'b0, '0, 1'b1, 14'd3);
        look(39'h400000);
        check("R7 alt entry survives", lk_hit, 1);
        fence(1'b0, '0, 1'b0, '0, 1'b1, 14'd7);
        look(39'h400000);
        check("R7 matching vmid fence", lk_hit, 0);

        // R9: alt register change flushes
        fill(27'h400, 44'hDDD, 16'd4, 14'd7, 1'b0);
        look(39'h400000);
        check("R9 refilled", lk_hit, 1);
        alt_asid = 16'd8;
        step();
        alt_asid = 16'd4;
        step();
        look(39'h400000);
        check("R9 flushed", lk_hit, 0);

        // R8: bare pass-through
        alt_bare = 1'b1;
        step();
        look(39'h12345678);
        check("R8 hit", lk_hit, 1);
        check("R8 pa", lk_pa, 56'h12345678);
        check("R8 no req", rf_req, 0);

        // R10: fill racing a fence
        alt_bare = 1'b0; mode_alt = 1'b0;
        step();
        fn_valid = 1'b1; fn_va_en = 1'b1; fn_vpn = 27'h500;
        fn_asid_en = 1'b0; fn_vmid_en = 1'b0;
        fill(27'h500, 44'h555, 16'd5, 14'd2, 1'b0);
        fn_valid = 1'b0;
        look(39'h500000);
        check("R10 fence wins", lk_hit, 0);
        fn_valid = 1'b1; fn_vpn = 27'h700;
        fill(27'h600, 44'h666, 16'd5, 14'd2, 1'b0);
        fn_valid = 1'b0;
        look(39'h600000);
        check("R10 unrelated fence", lk_pa, 56'h666000);
        check("R10 unrelated hit", lk_hit, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule